// File: doc/BRIEF.md
# Sorted Flip-Pattern Generator

This block enumerates low-cost bit-flip hypotheses for one half of a soft-decision codeword. At a start strobe it captures K unsigned reliability magnitudes and the K hard-decision bits. It then streams exactly RHO flip patterns, one per clock. Each pattern comes with its cost, the sum of the magnitudes of the bits it flips, and with the candidate word formed by XORing the pattern into the captured hard decision. The stream is in non-decreasing cost order. The RHO patterns it emits are always a cheapest possible set of RHO distinct patterns over all 2^K subsets. It is not restricted to combinations of the few least reliable bits.

The generator is a serial chain of K merge elements fed by a seed stage that emits the empty pattern. Element i holds the sorted stream that arrives from its predecessor in a small buffer. It merges that stream with a copy of itself in which bit i is set and magnitude i is added to every cost, and it keeps only the first RHO results. A downstream encoder and distance unit consume the candidates. Stopping decisions are made outside this block.

Top module: `flip_pattern_gen`

## Requirements
- R1: After reset, `out_valid` stays low until a start strobe has been sampled.
- R2: With OUT_REG = 0, `out_valid` first rises 2K clock edges after the edge that samples `start`. It then stays high for exactly RHO consecutive cycles and falls.
- R3: The first candidate of every word is the all-zero pattern with cost 0.
- R4: Within a word, `out_cost` never decreases from one candidate to the next.
- R5: `out_cost` equals the sum of the magnitudes whose pattern bit is set. Bit i of `out_pattern` selects magnitude field i, which is `mag_in[i*MW +: MW]`.
- R6: No pattern repeats within one word, even when magnitudes tie or are zero.
- R7: The sequence of costs equals the RHO smallest values of the multiset of all 2^K subset sums, in ascending order.
- R8: `out_word` equals `out_pattern` XOR the hard-decision bits captured at start.
- R9: `mag_in` and `hard_in` are captured only on the start cycle, so later changes do not affect the running word. A new start aborts a word in progress, and only the new word's candidates appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and begin a new word |
| mag_in | input | K*MW | Unsigned magnitudes, field i at bits i*MW +: MW |
| hard_in | input | K | Hard-decision bits of the half-word |
| out_valid | output | 1 | Candidate present this cycle |
| out_pattern | output | K | Flip pattern, bit i flips position i |
| out_word | output | K | Candidate word (pattern XOR captured hard bits) |
| out_cost | output | MW+clog2(K) | Sum of flipped magnitudes |

## Verification
The hardest cases to reach are those where the merge in an element must take from its shifted copy several times in a row, or where costs tie exactly. Only in those cases does a wrong pointer advance or a wrong tie rule produce a duplicate or an out-of-order cost. The stimulus therefore includes all-equal magnitudes, all-zero magnitudes, and the case of a few unreliable bits beside several of equal weight. It also includes random words, and every stream is compared with a brute-force histogram of all 4096 subset sums. An abort is provoked by issuing a second start while the first word is still filling the chain. The inputs are scrambled right after each start.

// File: rtl/fpg_seed.sv
module fpg_seed #(
   parameter int RHO   = 16,
   parameter int CNT_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic beat_o,
   output logic vld_o
);
   logic [CNT_W-1:0] cnt;

   // One real item (the empty pattern) followed by RHO-1 padding beats.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_o <= 1'b0;
         vld_o  <= 1'b0;
         cnt    <= '0;
      end else if (start) begin
         beat_o <= 1'b1;
         vld_o  <= 1'b1;
         cnt    <= CNT_W'(1);
      end else if (beat_o) begin
         vld_o <= 1'b0;
         if (cnt == CNT_W'(RHO)) beat_o <= 1'b0;
         else                    cnt    <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/fpg_pe.sv
module fpg_pe #(
   parameter int K   = 12,
   parameter int MW  = 6,
   parameter int CW  = 10,
   parameter int RHO = 16,
   parameter int IDX = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [MW-1:0] mag,
   input  logic          beat_i,
   input  logic          vld_i,
   input  logic [K-1:0]  pat_i,
   input  logic [CW-1:0] cost_i,
   output logic          beat_o,
   output logic          vld_o,
   output logic [K-1:0]  pat_o,
   output logic [CW-1:0] cost_o
);
   localparam int CNT_W = $clog2(RHO + 1);
   localparam int IW    = $clog2(RHO);

   logic [K-1:0]  pat_m  [RHO];
   logic [CW-1:0] cost_m [RHO];
   logic          vld_m  [RHO];

   logic [CNT_W-1:0] wr, pa, pb, n_out;
   logic [IW-1:0]    wr_i, pa_i, pb_i;
   assign wr_i = wr[IW-1:0];
   assign pa_i = pa[IW-1:0];
   assign pb_i = pb[IW-1:0];

   // Buffer of the incoming sorted stream (no reset needed: guarded by wr).
   always_ff @(posedge clk) begin
      if (beat_i && !start && (wr < CNT_W'(RHO))) begin
         pat_m[wr_i]  <= pat_i;
         cost_m[wr_i] <= cost_i;
         vld_m[wr_i]  <= vld_i;
      end
   end

   // Head of the unchanged stream and head of the bit-IDX-set stream.
   logic          a_v, b_v, take_b, emit;
   logic [K-1:0]  a_p, b_p;
   logic [CW-1:0] a_c, b_c;
   logic [CW:0]   b_sum;

   always_comb begin
      a_v    = vld_m[pa_i];
      a_p    = pat_m[pa_i];
      a_c    = cost_m[pa_i];
      b_v    = vld_m[pb_i];
      b_p    = pat_m[pb_i] | (K'(1) << IDX);
      b_sum  = {1'b0, cost_m[pb_i]} + {{(CW + 1 - MW){1'b0}}, mag};
      b_c    = b_sum[CW] ? {CW{1'b1}} : b_sum[CW-1:0];
      take_b = b_v && (!a_v || (b_c < a_c));
      emit   = (wr > n_out) && (n_out < CNT_W'(RHO));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr <= '0; pa <= '0; pb <= '0; n_out <= '0;
         beat_o <= 1'b0; vld_o <= 1'b0; pat_o <= '0; cost_o <= '0;
      end else if (start) begin
         wr <= '0; pa <= '0; pb <= '0; n_out <= '0;
         beat_o <= 1'b0;
      end else begin
         if (beat_i && (wr < CNT_W'(RHO))) wr <= wr + 1'b1;
         beat_o <= emit;
         if (emit) begin
            n_out <= n_out + 1'b1;
            if (take_b) begin
               vld_o  <= b_v;
               pat_o  <= b_p;
               cost_o <= b_c;
               pb     <= pb + 1'b1;
            end else begin
               vld_o  <= a_v;
               pat_o  <= a_p;
               cost_o <= a_c;
               pa     <= pa + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/flip_pattern_gen.sv
module flip_pattern_gen #(
   parameter int K       = 12,
   parameter int MW      = 6,
   parameter int RHO     = 16,
   parameter bit OUT_REG = 1'b0,
   localparam int CW     = MW + $clog2(K)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [K*MW-1:0] mag_in,
   input  logic [K-1:0]    hard_in,
   output logic            out_valid,
   output logic [K-1:0]    out_pattern,
   output logic [K-1:0]    out_word,
   output logic [CW-1:0]   out_cost
);
   localparam int CNT_W = $clog2(RHO + 1);

   if (K < 2) begin : g_bad_k
      $error("flip_pattern_gen: K must be at least 2");
   end
   if (RHO < 2 || RHO > (1 << K)) begin : g_bad_rho
      $error("flip_pattern_gen: RHO must lie in 2..2**K");
   end
   if (MW < 1) begin : g_bad_mw
      $error("flip_pattern_gen: MW must be positive");
   end

   logic [K*MW-1:0] mag_q;
   logic [K-1:0]    hard_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q  <= '0;
         hard_q <= '0;
      end else if (start) begin
         mag_q  <= mag_in;
         hard_q <= hard_in;
      end
   end

   logic          beat_c [K+1];
   logic          vld_c  [K+1];
   logic [K-1:0]  pat_c  [K+1];
   logic [CW-1:0] cost_c [K+1];

   assign pat_c[0]  = '0;
   assign cost_c[0] = '0;

   fpg_seed #(.RHO(RHO), .CNT_W(CNT_W)) u_seed (
      .clk(clk), .rst_n(rst_n), .start(start),
      .beat_o(beat_c[0]), .vld_o(vld_c[0])
   );

   for (genvar g = 0; g < K; g++) begin : g_pe
      fpg_pe #(.K(K), .MW(MW), .CW(CW), .RHO(RHO), .IDX(g)) u_pe (
         .clk(clk), .rst_n(rst_n), .start(start),
         .mag(mag_q[g*MW +: MW]),
         .beat_i(beat_c[g]), .vld_i(vld_c[g]),
         .pat_i(pat_c[g]), .cost_i(cost_c[g]),
         .beat_o(beat_c[g+1]), .vld_o(vld_c[g+1]),
         .pat_o(pat_c[g+1]), .cost_o(cost_c[g+1])
      );
   end

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0; out_pattern <= '0; out_word <= '0; out_cost <= '0;
         end else if (start) begin
            out_valid <= 1'b0;
         end else begin
            out_valid   <= beat_c[K] && vld_c[K];
            out_pattern <= pat_c[K];
            out_word    <= pat_c[K] ^ hard_q;
            out_cost    <= cost_c[K];
         end
      end
   end else begin : g_ocomb
      assign out_valid   = beat_c[K] && vld_c[K];
      assign out_pattern = pat_c[K];
      assign out_word    = pat_c[K] ^ hard_q;
      assign out_cost    = cost_c[K];
   end
endmodule

// File: rtl/flip_pattern_gen_chk.sv
module flip_pattern_gen_chk #(
   parameter int K   = 12,
   parameter int RHO = 16,
   parameter int CW  = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [K-1:0]  hard_in,
   input logic          out_valid,
   input logic [K-1:0]  out_pattern,
   input logic [K-1:0]  out_word,
   input logic [CW-1:0] out_cost
);
   localparam int CNT_W = $clog2(RHO + 1);

   logic             armed;
   logic [CNT_W-1:0] beats;
   logic [CW-1:0]    prev_cost;
   logic [K-1:0]     hard_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0; beats <= '0; prev_cost <= '0; hard_cap <= '0;
      end else if (start) begin
         armed <= 1'b1; beats <= '0; hard_cap <= hard_in;
      end else if (out_valid) begin
         if (beats < CNT_W'(RHO)) beats <= beats + 1'b1;
         prev_cost <= out_cost;
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !out_valid);

   // R2
   beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (beats < CNT_W'(RHO)));

   // R3
   first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && beats == '0) |-> (out_pattern == '0 && out_cost == '0));

   // R4
   cost_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && beats != '0) |-> (out_cost >= prev_cost));

   // R8
   word_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_word ^ out_pattern) == hard_cap));
endmodule

bind flip_pattern_gen flip_pattern_gen_chk #(.K(K), .RHO(RHO), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .hard_in(hard_in),
   .out_valid(out_valid), .out_pattern(out_pattern),
   .out_word(out_word), .out_cost(out_cost)
);

// File: tb/flip_pattern_gen_tb.sv
`timescale 1ns/1ps
module flip_pattern_gen_tb;
   localparam int K   = 12;
   localparam int MW  = 6;
   localparam int RHO = 16;
   localparam int CW  = MW + $clog2(K);
   localparam int NS  = 1 << K;
   localparam int LAT = 2*K + 1;   // negedges from start-visible to first beat (R2)

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [K*MW-1:0] mag_in = '0;
   logic [K-1:0]    hard_in = '0;
   logic            out_valid;
   logic [K-1:0]    out_pattern, out_word;
   logic [CW-1:0]   out_cost;

   always #4 clk = ~clk;  // 125 MHz

   flip_pattern_gen #(.K(K), .MW(MW), .RHO(RHO)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mag_in(mag_in), .hard_in(hard_in),
      .out_valid(out_valid), .out_pattern(out_pattern), .out_word(out_word),
      .out_cost(out_cost)
   );

   int n_chk = 0, n_fail = 0;
   int exp_q[$];
   int cur_mag[K];
   logic [K-1:0] cur_hard;
   bit seen[NS];
   int beats = 0, lat = 0, prev = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push_expected();
      int hist[1024];
      int pushed = 0;
      foreach (hist[i]) hist[i] = 0;
      for (int s = 0; s < NS; s++) begin
         int sum = 0;
         for (int b = 0; b < K; b++) if (s[b]) sum += cur_mag[b];
         hist[sum]++;
      end
      for (int c = 0; c < 1024 && pushed < RHO; c++)
         for (int r = 0; r < hist[c] && pushed < RHO; r++) begin
            exp_q.push_back(c);
            pushed++;
         end
   endtask

   task automatic start_word(input int m[K], input logic [K-1:0] h, input bit expect_out);
      @(posedge clk); #1;
      for (int i = 0; i < K; i++) mag_in[i*MW +: MW] = MW'(m[i]);
      hard_in = h;
      start = 1'b1;
      if (expect_out) begin
         cur_mag = m;
         cur_hard = h;
         exp_q.delete();
         push_expected();
         foreach (seen[i]) seen[i] = 1'b0;
         beats = 0;
      end
      @(posedge clk); #1;
      start = 1'b0;
      mag_in = ~mag_in;      // R9: post-start changes must be ignored
      hard_in = ~h;
   endtask

   task automatic finish_word();
      repeat (2*K + RHO + 6) @(posedge clk);
      #1;
      check(beats == RHO, "R2 beat count", beats, RHO);
      check(exp_q.size() == 0, "R7 missing candidates", exp_q.size(), 0);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (start) lat = 0; else lat++;
      if (rst_n && out_valid) begin
         int e, s;
         if (beats == 0) begin
            check(lat == LAT, "R2 latency", lat, LAT);
            check(out_pattern == '0 && out_cost == '0, "R3 first pattern",
                  int'(out_pattern), 0);
         end
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected beat", int'(out_cost), -1);
         end else begin
            e = exp_q.pop_front();
            check(int'(out_cost) == e, "R7 cost sequence", int'(out_cost), e);
         end
         s = 0;
         for (int b = 0; b < K; b++) if (out_pattern[b]) s += cur_mag[b];
         check(int'(out_cost) == s, "R5 cost sum", int'(out_cost), s);
         check(!seen[out_pattern], "R6 repeat", int'(out_pattern), -1);
         seen[out_pattern] = 1'b1;
         if (beats > 0) check(int'(out_cost) >= prev, "R4 order", int'(out_cost), prev);
         check(out_word == (out_pattern ^ cur_hard), "R8 word",
               int'(out_word), int'(out_pattern ^ cur_hard));
         prev = int'(out_cost);
         beats++;
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int w[K];
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: quiet after reset with no start
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R1 idle", int'(out_valid), 0);
      end
      // Few weak bits beside several equal-weight bits
      w = '{35, 20, 10, 35, 30, 50, 60, 55, 45, 40, 63, 62};
      start_word(w, 12'hA5C, 1'b1); finish_word();
      // All equal
      foreach (w[i]) w[i] = 9;
      start_word(w, 12'h0F0, 1'b1); finish_word();
      // All zero: every cost ties at 0, patterns must stay distinct (R6)
      foreach (w[i]) w[i] = 0;
      start_word(w, 12'hFFF, 1'b1); finish_word();
      // Ascending
      foreach (w[i]) w[i] = i * 5;
      start_word(w, 12'h123, 1'b1); finish_word();
      // All at maximum
      foreach (w[i]) w[i] = 63;
      start_word(w, 12'h800, 1'b1); finish_word();
      // Random words
      for (int t = 0; t < 4; t++) begin
         foreach (w[i]) w[i] = int'($urandom_range(0, 63));
         start_word(w, K'($urandom), 1'b1); finish_word();
      end
      // R9: abort a word still filling the chain, then restart
      foreach (w[i]) w[i] = 1;
      start_word(w, 12'h555, 1'b0);
      repeat (5) @(posedge clk);
      foreach (w[i]) w[i] = 63 - 4*i;
      start_word(w, 12'h3C3, 1'b1); finish_word();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule